// File: doc/BRIEF.md
# Bus Address Trap Unit

A debug monitor that watches every transaction on a system bus and compares it, in the same cycle, against four independent trap comparators. Each trap has an inclusive physical address window, an access-kind selector, an optional source-ID comparison, and flags that invert the window test and the source test. A trap can therefore flag accesses inside or outside a region, by one agent or by every agent but one. The unit only detects; it never blocks or alters the observed transaction.

Each trap owns a 3-bit occurrence counter that steps down on every hit and saturates at zero. While the interrupt is low, every hit records the address and the number of the trap into one shared log. The first 1-to-0 counter step of any trap raises a sticky interrupt, which freezes the log. Software reads the log index first and then the log address, and that second read drops the interrupt. A one-cycle hit strobe per trap feeds performance counters or trace logic whatever the counter value.

The observation port uses a valid/ready pair. `mon_ready` is held high at all times: the monitor never applies back-pressure, and a transaction is observed in every cycle where `mon_valid` is high. The register port is a plain single-cycle read/write strobe with combinational read data.

Top module: `addr_trap_unit`

## Requirements
- R1: A trap's window test is true when lower <= address <= upper, both bounds inclusive, so equal bounds select one address; cfg bit 2 set inverts the test, so the trap then fires only outside the window.
- R2: cfg bits 1:0 select the access kind: 00 disabled (never hits), 01 reads only, 10 writes only, 11 every access.
- R3: cfg bit 3 enables the source test; the observed 4-bit initiator ID is compared with cfg bits 11:8 and must be equal when cfg bit 4 is 0 or different when it is 1; with bit 3 clear the source is ignored.
- R4: `trap_hit[i]` is high for exactly the cycle after each observed transaction that trap i qualifies on, whatever its counter value; `mon_ready` is always 1.
- R5: The counter in cfg bits 7:5 drops by one on every hit while non-zero and stays at zero once reached.
- R6: `trap_irq` rises in the cycle after any trap's counter steps from 1 to 0.
- R7: While `trap_irq` is low, a hit records its address and trap number in the log; when several traps hit together the lowest-numbered one is recorded.
- R8: While `trap_irq` is high the log keeps its contents, yet counters go on decrementing on further hits.
- R9: A read of the log-address register drops `trap_irq` in the next cycle unless a new 1-to-0 step arrives; a read of the log-index register does not.
- R10: If a log-address read coincides with a hit, the hit is recorded in the log, and if it is a 1-to-0 step the interrupt stays high (raise wins over clear).
- R11: A cfg write in the same cycle as a hit on that trap loads the written count, takes no 1-to-0 step from that hit, and the hit strobe still fires under the old settings.
- R12: Register map, `reg_addr` = {trap[1:0], sel[1:0]}: sel 0 lower bound, 1 upper bound, 2 cfg (count read live); sel 3 at trap 0 is the log address, at trap 1 the log index in bits 1:0; all registers, the log and the interrupt reset to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mon_valid | input | 1 | Observed transaction present |
| mon_ready | output | 1 | Always 1; monitor never stalls the bus |
| mon_addr | input | 40 | Physical address of the transaction |
| mon_write | input | 1 | 1 for a write, 0 for a read |
| mon_src | input | 4 | Initiator source ID of the transaction |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe (has the clearing side effect) |
| reg_addr | input | 4 | Register select {trap, sel} |
| reg_wdata | input | 40 | Register write data |
| reg_rdata | output | 40 | Register read data, combinational |
| trap_hit | output | 4 | Per-trap one-cycle hit strobe |
| trap_irq | output | 1 | Sticky trap interrupt |

## Verification
Two pairs of functions share a cycle here: the software clear of the interrupt against a trap hit, and a software cfg write against a hit that would decrement the same counter. The bench drives the log-address read and an observed transaction on the same clock edge, once with a terminal 1-to-0 hit and once with a non-terminal hit, and judges the result by the interrupt level and the log contents read afterwards. It likewise lands a cfg write on the edge of a matching transaction and checks the hit strobe, the read-back count and that no interrupt was raised from a count of one.

// File: rtl/addr_trap_pkg.sv
package addr_trap_pkg;

  typedef enum logic [1:0] {
    KIND_OFF = 2'b00,
    KIND_RD  = 2'b01,
    KIND_WR  = 2'b10,
    KIND_ANY = 2'b11
  } acc_kind_e;

  localparam logic [1:0] SEL_LO  = 2'd0;
  localparam logic [1:0] SEL_HI  = 2'd1;
  localparam logic [1:0] SEL_CFG = 2'd2;
  localparam logic [1:0] SEL_LOG = 2'd3;

  localparam int CFG_OUT_BIT   = 2;
  localparam int CFG_SRCEN_BIT = 3;
  localparam int CFG_SRCNE_BIT = 4;
  localparam int CFG_CNT_LSB   = 5;

  function automatic logic kind_ok(input acc_kind_e kind, input logic is_write);
    unique case (kind)
      KIND_RD:  kind_ok = !is_write;
      KIND_WR:  kind_ok = is_write;
      KIND_ANY: kind_ok = 1'b1;
      default:  kind_ok = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/addr_trap_cmp.sv
module addr_trap_cmp
  import addr_trap_pkg::*;
#(
  parameter int ADDR_W = 40,
  parameter int SRC_W  = 4
) (
  input  logic              valid,
  input  logic              is_write,
  input  logic [ADDR_W-1:0] addr,
  input  logic [SRC_W-1:0]  src,
  input  logic [ADDR_W-1:0] lo,
  input  logic [ADDR_W-1:0] hi,
  input  acc_kind_e         kind,
  input  logic              outside,
  input  logic              src_en,
  input  logic              src_ne,
  input  logic [SRC_W-1:0]  src_id,
  output logic              match
);

  logic in_window;
  logic src_pass;

  always_comb begin
    in_window = (addr >= lo) && (addr <= hi);
    src_pass  = !src_en || ((src == src_id) != src_ne);
    match     = valid && kind_ok(kind, is_write) && (in_window != outside) && src_pass;
  end

endmodule

// File: rtl/addr_trap_slot.sv
module addr_trap_slot
  import addr_trap_pkg::*;
#(
  parameter int ADDR_W = 40,
  parameter int SRC_W  = 4,
  parameter int CNT_W  = 3,
  parameter int REG_W  = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic              wr_cfg,
  input  logic [REG_W-1:0]  wdata,
  input  logic              mon_valid,
  input  logic              mon_write,
  input  logic [ADDR_W-1:0] mon_addr,
  input  logic [SRC_W-1:0]  mon_src,
  output logic [ADDR_W-1:0] lo_q,
  output logic [ADDR_W-1:0] hi_q,
  output logic [REG_W-1:0]  cfg_word,
  output logic [CNT_W-1:0]  cnt_q,
  output logic              match,
  output logic              terminal,
  output logic              hit_q
);

  localparam int SRC_LSB = CFG_CNT_LSB + CNT_W;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  acc_kind_e        kind_q;
  logic             out_q;
  logic             sen_q;
  logic             sne_q;
  logic [SRC_W-1:0] src_q;

  addr_trap_cmp #(.ADDR_W(ADDR_W), .SRC_W(SRC_W)) u_cmp (
    .valid    (mon_valid),
    .is_write (mon_write),
    .addr     (mon_addr),
    .src      (mon_src),
    .lo       (lo_q),
    .hi       (hi_q),
    .kind     (kind_q),
    .outside  (out_q),
    .src_en   (sen_q),
    .src_ne   (sne_q),
    .src_id   (src_q),
    .match    (match)
  );

  // a cfg write on the same edge overrides the decrement, so no terminal step
  assign terminal = match && !wr_cfg && (cnt_q == CNT_ONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q   <= '0;
      hi_q   <= '0;
      kind_q <= KIND_OFF;
      out_q  <= 1'b0;
      sen_q  <= 1'b0;
      sne_q  <= 1'b0;
      src_q  <= '0;
      cnt_q  <= '0;
      hit_q  <= 1'b0;
    end else begin
      hit_q <= match;
      if (wr_lo) lo_q <= wdata[ADDR_W-1:0];
      if (wr_hi) hi_q <= wdata[ADDR_W-1:0];
      if (wr_cfg) begin
        kind_q <= acc_kind_e'(wdata[1:0]);
        out_q  <= wdata[CFG_OUT_BIT];
        sen_q  <= wdata[CFG_SRCEN_BIT];
        sne_q  <= wdata[CFG_SRCNE_BIT];
        src_q  <= wdata[SRC_LSB +: SRC_W];
        cnt_q  <= wdata[CFG_CNT_LSB +: CNT_W];
      end else if (match && (cnt_q != '0)) begin
        cnt_q <= cnt_q - CNT_ONE;
      end
    end
  end

  always_comb begin
    cfg_word                          = '0;
    cfg_word[1:0]                     = kind_q;
    cfg_word[CFG_OUT_BIT]             = out_q;
    cfg_word[CFG_SRCEN_BIT]           = sen_q;
    cfg_word[CFG_SRCNE_BIT]           = sne_q;
    cfg_word[CFG_CNT_LSB +: CNT_W]    = cnt_q;
    cfg_word[SRC_LSB +: SRC_W]        = src_q;
  end

endmodule

// File: rtl/addr_trap_log.sv
module addr_trap_log #(
  parameter int N_TRAPS = 4,
  parameter int ADDR_W  = 40,
  localparam int IDX_W  = $clog2(N_TRAPS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_TRAPS-1:0] match,
  input  logic [N_TRAPS-1:0] terminal,
  input  logic [ADDR_W-1:0]  mon_addr,
  input  logic               clear_req,
  output logic [ADDR_W-1:0]  log_addr,
  output logic [IDX_W-1:0]   log_idx,
  output logic               irq
);

  logic [IDX_W-1:0] first_idx;
  logic             log_en;

  always_comb begin
    first_idx = '0;
    for (int i = N_TRAPS - 1; i >= 0; i--) begin
      if (match[i]) first_idx = IDX_W'(i);
    end
    // a clear on this edge reopens the log for a hit on the same edge
    log_en = (|match) && (!irq || clear_req);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      log_addr <= '0;
      log_idx  <= '0;
      irq      <= 1'b0;
    end else begin
      if (log_en) begin
        log_addr <= mon_addr;
        log_idx  <= first_idx;
      end
      if (|terminal)     irq <= 1'b1;
      else if (clear_req) irq <= 1'b0;
    end
  end

endmodule

// File: rtl/addr_trap_unit.sv
module addr_trap_unit
  import addr_trap_pkg::*;
#(
  parameter int N_TRAPS = 4,
  parameter int ADDR_W  = 40,
  parameter int SRC_W   = 4,
  parameter int CNT_W   = 3,
  parameter int REG_W   = 40,
  localparam int IDX_W  = $clog2(N_TRAPS),
  localparam int RA_W   = IDX_W + 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mon_valid,
  output logic               mon_ready,
  input  logic [ADDR_W-1:0]  mon_addr,
  input  logic               mon_write,
  input  logic [SRC_W-1:0]   mon_src,
  input  logic               reg_wr_en,
  input  logic               reg_rd_en,
  input  logic [RA_W-1:0]    reg_addr,
  input  logic [REG_W-1:0]   reg_wdata,
  output logic [REG_W-1:0]   reg_rdata,
  output logic [N_TRAPS-1:0] trap_hit,
  output logic               trap_irq
);

  localparam logic [RA_W-1:0] LOG_ADDR_RA = {IDX_W'(0), SEL_LOG};
  localparam logic [RA_W-1:0] LOG_IDX_RA  = {IDX_W'(1), SEL_LOG};

  logic [ADDR_W-1:0]        lo_arr  [N_TRAPS];
  logic [ADDR_W-1:0]        hi_arr  [N_TRAPS];
  logic [REG_W-1:0]         cfg_arr [N_TRAPS];
  logic [N_TRAPS-1:0]       match_v;
  logic [N_TRAPS-1:0]       term_v;
  logic [N_TRAPS-1:0]       cfg_wr_v;
  logic [N_TRAPS*CNT_W-1:0] cnt_flat;
  logic [ADDR_W-1:0]        log_addr_q;
  logic [IDX_W-1:0]         log_idx_q;
  logic                     clear_req;

  assign mon_ready = 1'b1;
  assign clear_req = reg_rd_en && (reg_addr == LOG_ADDR_RA);

  for (genvar i = 0; i < N_TRAPS; i++) begin : g_trap
    localparam logic [IDX_W-1:0] TI = IDX_W'(i);
    logic wr_lo, wr_hi;
    assign wr_lo       = reg_wr_en && (reg_addr == {TI, SEL_LO});
    assign wr_hi       = reg_wr_en && (reg_addr == {TI, SEL_HI});
    assign cfg_wr_v[i] = reg_wr_en && (reg_addr == {TI, SEL_CFG});

    addr_trap_slot #(
      .ADDR_W (ADDR_W),
      .SRC_W  (SRC_W),
      .CNT_W  (CNT_W),
      .REG_W  (REG_W)
    ) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_lo     (wr_lo),
      .wr_hi     (wr_hi),
      .wr_cfg    (cfg_wr_v[i]),
      .wdata     (reg_wdata),
      .mon_valid (mon_valid),
      .mon_write (mon_write),
      .mon_addr  (mon_addr),
      .mon_src   (mon_src),
      .lo_q      (lo_arr[i]),
      .hi_q      (hi_arr[i]),
      .cfg_word  (cfg_arr[i]),
      .cnt_q     (cnt_flat[i*CNT_W +: CNT_W]),
      .match     (match_v[i]),
      .terminal  (term_v[i]),
      .hit_q     (trap_hit[i])
    );
  end

  addr_trap_log #(.N_TRAPS(N_TRAPS), .ADDR_W(ADDR_W)) u_log (
    .clk       (clk),
    .rst_n     (rst_n),
    .match     (match_v),
    .terminal  (term_v),
    .mon_addr  (mon_addr),
    .clear_req (clear_req),
    .log_addr  (log_addr_q),
    .log_idx   (log_idx_q),
    .irq       (trap_irq)
  );

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr[1:0])
      SEL_LO:  reg_rdata[ADDR_W-1:0] = lo_arr[reg_addr[RA_W-1:2]];
      SEL_HI:  reg_rdata[ADDR_W-1:0] = hi_arr[reg_addr[RA_W-1:2]];
      SEL_CFG: reg_rdata             = cfg_arr[reg_addr[RA_W-1:2]];
      default: begin
        if (reg_addr == LOG_ADDR_RA)     reg_rdata[ADDR_W-1:0] = log_addr_q;
        else if (reg_addr == LOG_IDX_RA) reg_rdata[IDX_W-1:0]  = log_idx_q;
      end
    endcase
  end

endmodule

// File: rtl/addr_trap_unit_chk.sv
module addr_trap_unit_chk #(
  parameter int N_TRAPS = 4,
  parameter int ADDR_W  = 40,
  parameter int CNT_W   = 3,
  parameter int IDX_W   = 2
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     mon_valid,
  input logic                     clear_req,
  input logic [N_TRAPS-1:0]       trap_hit,
  input logic                     trap_irq,
  input logic [ADDR_W-1:0]        log_addr,
  input logic [IDX_W-1:0]         log_idx,
  input logic [N_TRAPS-1:0]       cfg_wr,
  input logic [N_TRAPS*CNT_W-1:0] cnt_flat
);

  AST_HIT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (|trap_hit) |-> $past(mon_valid)); // R4

  AST_IRQ_RISES_WITH_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trap_irq) |-> (|trap_hit)); // R6

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_irq && !clear_req) |=> trap_irq); // R8

  AST_LOG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_irq && !clear_req) |=> ($stable(log_addr) && $stable(log_idx))); // R8

  AST_CLEAR_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    clear_req |=> (!trap_irq || (|trap_hit))); // R9

  for (genvar i = 0; i < N_TRAPS; i++) begin : g_cnt
    AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
      ((cnt_flat[i*CNT_W +: CNT_W] == '0) && !cfg_wr[i]) |=>
        (cnt_flat[i*CNT_W +: CNT_W] == '0)); // R5
  end

endmodule

bind addr_trap_unit addr_trap_unit_chk #(
  .N_TRAPS (N_TRAPS),
  .ADDR_W  (ADDR_W),
  .CNT_W   (CNT_W),
  .IDX_W   (IDX_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mon_valid (mon_valid),
  .clear_req (clear_req),
  .trap_hit  (trap_hit),
  .trap_irq  (trap_irq),
  .log_addr  (log_addr_q),
  .log_idx   (log_idx_q),
  .cfg_wr    (cfg_wr_v),
  .cnt_flat  (cnt_flat)
);

// File: tb/addr_trap_unit_tb.sv
module addr_trap_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mon_valid = 1'b0;
  logic        mon_ready;
  logic [39:0] mon_addr = '0;
  logic        mon_write = 1'b0;
  logic [3:0]  mon_src = '0;
  logic        reg_wr_en = 1'b0;
  logic        reg_rd_en = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [39:0] reg_wdata = '0;
  logic [39:0] reg_rdata;
  logic [3:0]  trap_hit;
  logic        trap_irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  addr_trap_unit u_dut (
    .clk(clk), .rst_n(rst_n), .mon_valid(mon_valid), .mon_ready(mon_ready),
    .mon_addr(mon_addr), .mon_write(mon_write), .mon_src(mon_src),
    .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .trap_hit(trap_hit),
    .trap_irq(trap_irq)
  );

  localparam logic [3:0] RA_LOG_ADDR = 4'b0011;
  localparam logic [3:0] RA_LOG_IDX  = 4'b0111;

  function automatic logic [3:0] ra(input int t, input int sel);
    return 4'((t << 2) | sel);
  endfunction

  function automatic logic [39:0] cfgw(input int kind, input bit outside, input bit sen,
                                       input bit sne, input int cnt, input int src);
    return 40'((kind & 3) | (int'(outside) << 2) | (int'(sen) << 3) | (int'(sne) << 4) |
               ((cnt & 7) << 5) | ((src & 15) << 8));
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [39:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [39:0] d);
    @(negedge clk);
    reg_rd_en = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(posedge clk); #1;
    reg_rd_en = 1'b0;
  endtask

  task automatic txn(input logic [39:0] a, input bit w, input logic [3:0] s);
    @(negedge clk);
    mon_valid = 1'b1; mon_addr = a; mon_write = w; mon_src = s;
    @(posedge clk); #1;
    mon_valid = 1'b0;
  endtask

  function automatic int cnt_of(input logic [39:0] d);
    return int'((d >> 5) & 40'd7);
  endfunction

  initial begin : watchdog
    #(5.0 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [39:0] d;
    logic [39:0] lo, hi;
    logic [39:0] pts [5];
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R12 reset state and register map
    check(trap_irq == 1'b0, "R12 irq after reset", 64'(trap_irq), 0);
    check(trap_hit == 4'b0, "R12 hits after reset", 64'(trap_hit), 0);
    check(mon_ready == 1'b1, "R4 mon_ready", 64'(mon_ready), 1);
    for (int t = 0; t < 4; t++) begin
      for (int s = 0; s < 4; s++) begin
        rd(ra(t, s), d);
        check(d == 40'd0, "R12 reset register zero", 64'(d), 0);
      end
    end
    wr(ra(3, 0), 40'h12_3456_789A);
    rd(ra(3, 0), d);
    check(d == 40'h12_3456_789A, "R12 lower bound readback", 64'(d), 64'h12_3456_789A);
    wr(ra(3, 0), 40'd0);

    // R1 R2 R3 R4 R7 sweep on trap 2, count 0 so the log stays open
    lo = 40'h10_0000_0100;
    hi = 40'h10_0000_01FF;
    pts[0] = lo - 40'd1; pts[1] = lo; pts[2] = lo + 40'h80; pts[3] = hi; pts[4] = hi + 40'd1;
    wr(ra(2, 0), lo);
    wr(ra(2, 1), hi);
    for (int kind = 0; kind < 4; kind++)
    for (int outside = 0; outside < 2; outside++)
    for (int sen = 0; sen < 2; sen++)
    for (int sne = 0; sne < 2; sne++) begin
      wr(ra(2, 2), cfgw(kind, outside[0], sen[0], sne[0], 0, 5));
      for (int p = 0; p < 5; p++)
      for (int w = 0; w < 2; w++)
      for (int si = 0; si < 2; si++) begin
        automatic logic [3:0] s = (si == 0) ? 4'd5 : 4'd9;
        automatic bit kok = (kind == 3) || (kind == 1 && w == 0) || (kind == 2 && w == 1);
        automatic bit inr = (pts[p] >= lo) && (pts[p] <= hi);
        automatic bit sok = (sen == 0) || ((s == 4'd5) != (sne == 1));
        automatic bit exp = kok && (inr != (outside == 1)) && sok;
        txn(pts[p], w[0], s);
        check(trap_hit == {1'b0, exp, 2'b00}, "R1 R2 R3 R4 hit strobe", 64'(trap_hit),
              64'({1'b0, exp, 2'b00}));
        if (exp) begin
          rd(RA_LOG_ADDR, d);
          check(d == pts[p], "R7 logged address", 64'(d), 64'(pts[p]));
        end
      end
    end
    wr(ra(2, 2), 40'd0);

    // R1 single-address window on trap 0
    wr(ra(0, 0), 40'h00_0000_4000);
    wr(ra(0, 1), 40'h00_0000_4000);
    wr(ra(0, 2), cfgw(3, 0, 0, 0, 0, 0));
    txn(40'h00_0000_3FFF, 1'b0, 4'd0);
    check(trap_hit == 4'b0000, "R1 equal bounds below", 64'(trap_hit), 0);
    txn(40'h00_0000_4000, 1'b0, 4'd0);
    check(trap_hit == 4'b0001, "R1 equal bounds exact", 64'(trap_hit), 1);
    txn(40'h00_0000_4001, 1'b1, 4'd0);
    check(trap_hit == 4'b0000, "R1 equal bounds above", 64'(trap_hit), 0);

    // R7 lowest-numbered trap wins the log
    for (int t = 0; t < 4; t++) begin
      wr(ra(t, 0), 40'h00_0000_8000);
      wr(ra(t, 1), 40'h00_0000_8FFF);
      wr(ra(t, 2), cfgw(3, 0, 0, 0, 0, 0));
    end
    txn(40'h00_0000_8010, 1'b1, 4'd3);
    check(trap_hit == 4'b1111, "R4 all traps strobe", 64'(trap_hit), 64'hF);
    rd(RA_LOG_IDX, d);
    check(d == 40'd0, "R7 lowest index logged", 64'(d), 0);
    wr(ra(0, 2), 40'd0);
    txn(40'h00_0000_8020, 1'b0, 4'd3);
    rd(RA_LOG_IDX, d);
    check(d == 40'd1, "R7 next lowest index", 64'(d), 1);
    wr(ra(2, 2), 40'd0);
    wr(ra(3, 2), 40'd0);

    // R5 R6 R8 R9 counter, interrupt and freeze on trap 1
    wr(ra(1, 2), cfgw(2, 0, 0, 0, 3, 0));
    txn(40'h00_0000_8100, 1'b1, 4'd1);
    rd(ra(1, 2), d);
    check(cnt_of(d) == 2, "R5 count after first hit", 64'(cnt_of(d)), 2);
    txn(40'h00_0000_8200, 1'b0, 4'd1);
    check(trap_hit == 4'b0000, "R2 read ignored by write trap", 64'(trap_hit), 0);
    txn(40'h00_0000_8300, 1'b1, 4'd1);
    check(trap_irq == 1'b0, "R6 no irq at 2 to 1", 64'(trap_irq), 0);
    txn(40'h00_0000_8400, 1'b1, 4'd1);
    check(trap_irq == 1'b1, "R6 irq at 1 to 0", 64'(trap_irq), 1);
    wr(ra(3, 2), cfgw(3, 0, 0, 0, 5, 0));
    txn(40'h00_0000_8500, 1'b1, 4'd1);
    check(trap_hit == 4'b1010, "R4 strobe with count zero", 64'(trap_hit), 64'hA);
    rd(ra(1, 2), d);
    check(cnt_of(d) == 0, "R5 saturates at zero", 64'(cnt_of(d)), 0);
    rd(ra(3, 2), d);
    check(cnt_of(d) == 4, "R8 counter runs while frozen", 64'(cnt_of(d)), 4);
    rd(RA_LOG_IDX, d);
    check(d == 40'd1, "R8 index frozen", 64'(d), 1);
    check(trap_irq == 1'b1, "R9 index read keeps irq", 64'(trap_irq), 1);
    rd(RA_LOG_ADDR, d);
    check(d == 40'h00_0000_8400, "R8 address frozen", 64'(d), 64'h8400);
    check(trap_irq == 1'b0, "R9 address read clears irq", 64'(trap_irq), 0);
    wr(ra(3, 2), 40'd0);

    // R10 clear coinciding with a terminal hit
    wr(ra(1, 2), cfgw(3, 0, 0, 0, 1, 0));
    txn(40'h00_0000_8600, 1'b0, 4'd0);
    check(trap_irq == 1'b1, "R6 irq raised again", 64'(trap_irq), 1);
    wr(ra(1, 2), cfgw(3, 0, 0, 0, 1, 0));
    @(negedge clk);
    reg_rd_en = 1'b1; reg_addr = RA_LOG_ADDR;
    mon_valid = 1'b1; mon_addr = 40'h00_0000_8700; mon_write = 1'b0;
    @(posedge clk); #1;
    reg_rd_en = 1'b0; mon_valid = 1'b0;
    check(trap_irq == 1'b1, "R10 raise wins over clear", 64'(trap_irq), 1);
    rd(RA_LOG_ADDR, d);
    check(d == 40'h00_0000_8700, "R10 terminal hit logged", 64'(d), 64'h8700);

    // R10 clear coinciding with a non-terminal hit
    wr(ra(1, 2), cfgw(3, 0, 0, 0, 1, 0));
    txn(40'h00_0000_8800, 1'b1, 4'd0);
    wr(ra(1, 2), cfgw(3, 0, 0, 0, 3, 0));
    @(negedge clk);
    reg_rd_en = 1'b1; reg_addr = RA_LOG_ADDR;
    mon_valid = 1'b1; mon_addr = 40'h00_0000_8900; mon_write = 1'b1;
    @(posedge clk); #1;
    reg_rd_en = 1'b0; mon_valid = 1'b0;
    check(trap_irq == 1'b0, "R10 clear with plain hit", 64'(trap_irq), 0);
    rd(RA_LOG_ADDR, d);
    check(d == 40'h00_0000_8900, "R10 plain hit logged", 64'(d), 64'h8900);

    // R11 cfg write coinciding with a hit
    wr(ra(1, 2), cfgw(3, 0, 0, 0, 1, 0));
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = ra(1, 2); reg_wdata = cfgw(1, 0, 0, 0, 4, 0);
    mon_valid = 1'b1; mon_addr = 40'h00_0000_8A00; mon_write = 1'b1;
    @(posedge clk); #1;
    reg_wr_en = 1'b0; mon_valid = 1'b0;
    check(trap_hit == 4'b0010, "R11 strobe under old cfg", 64'(trap_hit), 2);
    check(trap_irq == 1'b0, "R11 no terminal step", 64'(trap_irq), 0);
    rd(ra(1, 2), d);
    check(cnt_of(d) == 4, "R11 written count wins", 64'(cnt_of(d)), 4);
    txn(40'h00_0000_8B00, 1'b1, 4'd0);
    check(trap_hit == 4'b0000, "R11 new kind in force", 64'(trap_hit), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule